// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block runs in the always-on slow clock domain. It decides when the main supply is switched off and when it comes back. Software starts a power-down by writing a 1 to bit 0 of the hibernate register. The sequencer then leaves the running state and drops the power-enable output. While powered down it watches an active-low wakeup pin. The pin must stay low for a programmed number of consecutive slow-clock ticks before it counts as a wakeup, which keeps short glitches from waking the system.

Once a wakeup qualifies, the block raises power-enable again. It then holds the active-low system reset output low for a programmed number of ticks, so the supply can settle before the main logic starts. Both durations are set through registers that keep only their upper bits, so the step size is 32 ticks. Every clock edge is one slow tick.

The controller has four states, visited in a fixed loop:
- RUN: powered, out of reset.
- HIBERNATE: unpowered, waiting for the pin.
- WAKE_FILTER: unpowered, timing the pin.
- RESET_HOLD: powered, reset asserted.

The transitions are:
- RUN → HIBERNATE on a hibernate write with bit 0 set.
- HIBERNATE → WAKE_FILTER on the first low sample of the pin.
- WAKE_FILTER → HIBERNATE if the pin goes high before the wakeup qualifies.
- WAKE_FILTER → RESET_HOLD once it qualifies.
- RESET_HOLD → RUN when the hold count expires.

Top module: `hib_seq`

## Requirements
- R1: After reset, power-enable is 1, system reset is 1, and all three registers read 0.
- R2: The wakeup filter register at offset 0x24 stores only write-data bits 15:5. All other bits read back as 0, so a write of 0xFFFFFFFF reads 0x0000FFE0.
- R3: The reset hold register at offset 0x28 stores only write-data bits 11:5. All other bits read back as 0, so a write of 0xFFFFFFFF reads 0x00000FE0.
- R4: Behaviour of the hibernate register at offset 0x20:
  - A write in RUN with write-data bit 0 set moves the block to HIBERNATE at that clock edge, and power-enable is low from that edge on.
  - A write with bit 0 clear has no effect.
  - Read bit 0 of this register is 1 while in HIBERNATE or WAKE_FILTER and 0 otherwise.
- R5: In HIBERNATE and WAKE_FILTER, power-enable is 0 and system reset stays 1.
- R6: Let F be the filter value, with F ≥ 1. A wakeup qualifies after the pin is sampled low on F consecutive edges, counting the edge that leaves HIBERNATE. RESET_HOLD is entered on the following edge.
- R7: If the pin is sampled high in WAKE_FILTER before the wakeup qualifies, the block returns to HIBERNATE and the count restarts from 0.
- R8: A filter value of 0 behaves like 1: a single low sample qualifies the wakeup.
- R9: In RESET_HOLD, power-enable is 1 and system reset is 0 for exactly max(H,1) ticks, where H is the reset hold value. After that the block returns to RUN with both outputs at 1.
- R10: In RUN, the wakeup pin has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; one edge per tick |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| wake_n | input | 1 | Active-low wakeup pin |
| pwr_en | output | 1 | Main power enable, 1 = powered |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The wakeup path is driven with four pin patterns:
- A steady low with a 64-tick filter. This separates a correct count from an off-by-one count.
- A filter of 0. This shows that a single sample is enough.
- A 40-tick pulse followed by a short release and a second assertion. This shows that the count restarts rather than resumes.
- A long low level while running. This shows that the pin is ignored outside hibernation.

Two reset-hold lengths are measured: the 32-tick minimum step and the 4064-tick maximum. The register tests write all-ones and mixed patterns, which exposes any stored or leaking bit outside the kept fields.

// File: rtl/hib_pkg.sv
package hib_pkg;
    typedef enum logic [1:0] {
        ST_RUN         = 2'd0,
        ST_HIBERNATE   = 2'd1,
        ST_WAKE_FILTER = 2'd2,
        ST_RESET_HOLD  = 2'd3
    } hib_state_t;
endpackage

// File: rtl/hib_regs.sv
module hib_regs #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int HIB_OFS = 'h20,
    parameter int FLT_OFS = 'h24,
    parameter int RST_OFS = 'h28,
    parameter int FLT_MSB = 15,
    parameter int RST_MSB = 11,
    parameter int LSB     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hibernating,
    output logic [DATA_W-1:0] rdata,
    output logic [FLT_MSB:0]  flt_val,
    output logic [RST_MSB:0]  rst_val,
    output logic              hib_req
);
    localparam logic [ADDR_W-1:0] A_HIB = ADDR_W'(HIB_OFS);
    localparam logic [ADDR_W-1:0] A_FLT = ADDR_W'(FLT_OFS);
    localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(RST_OFS);

    logic [FLT_MSB:LSB] flt_q;
    logic [RST_MSB:LSB] rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
            rst_q <= '0;
        end else if (we) begin
            if (addr == A_FLT) flt_q <= wdata[FLT_MSB:LSB];
            if (addr == A_RST) rst_q <= wdata[RST_MSB:LSB];
        end
    end

    assign flt_val = {flt_q, {LSB{1'b0}}};
    assign rst_val = {rst_q, {LSB{1'b0}}};
    assign hib_req = we && (addr == A_HIB) && wdata[0];

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_HIB:   rdata[0] = hibernating;
            A_FLT:   rdata[FLT_MSB:LSB] = flt_q;
            A_RST:   rdata[RST_MSB:LSB] = rst_q;
            default: rdata = '0;
        endcase
    end

    // R2
    flt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_FLT) |=> (flt_val == {$past(wdata[FLT_MSB:LSB]), {LSB{1'b0}}}));
endmodule

// File: rtl/hib_wake_filter.sv
module hib_wake_filter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic             wake_n,
    input  logic [CNT_W-1:0] limit,
    output logic             qualified
);
    logic [CNT_W-1:0] cnt_q;

    assign qualified = active && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(1);
        end else if (active && !qualified) begin
            if (wake_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
        end else if (!active) begin
            cnt_q <= '0;
        end
    end

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !qualified && wake_n) |=> (cnt_q == '0));
endmodule

// File: rtl/hib_rst_hold.sv
module hib_rst_hold #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   next_cnt;

    assign next_cnt = {1'b0, cnt_q} + 1'b1;
    assign done     = active && (next_cnt >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!active || done)  cnt_q <= '0;
        else                       cnt_q <= next_cnt[CNT_W-1:0];
    end
endmodule

// File: rtl/hib_seq.sv
module hib_seq
    import hib_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int HIB_OFS = 'h20,
    parameter int FLT_OFS = 'h24,
    parameter int RST_OFS = 'h28,
    parameter int FLT_MSB = 15,
    parameter int RST_MSB = 11,
    parameter int LSB     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wake_n,
    output logic              pwr_en,
    output logic              sys_rst_n
);
    localparam int FLT_W = FLT_MSB + 1;
    localparam int RST_W = RST_MSB + 1;

    hib_state_t       state_q, state_d;
    logic [FLT_W-1:0] flt_val;
    logic [RST_W-1:0] rst_val;
    logic             hib_req, qualified, hold_done, hibernating;

    assign hibernating = (state_q == ST_HIBERNATE) || (state_q == ST_WAKE_FILTER);

    hib_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HIB_OFS(HIB_OFS), .FLT_OFS(FLT_OFS),
        .RST_OFS(RST_OFS), .FLT_MSB(FLT_MSB), .RST_MSB(RST_MSB), .LSB(LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .hibernating(hibernating), .rdata(bus_rdata), .flt_val(flt_val),
        .rst_val(rst_val), .hib_req(hib_req)
    );

    hib_wake_filter #(.CNT_W(FLT_W)) u_filter (
        .clk(clk), .rst_n(rst_n),
        .start((state_q == ST_HIBERNATE) && !wake_n),
        .active(state_q == ST_WAKE_FILTER),
        .wake_n(wake_n), .limit(flt_val), .qualified(qualified)
    );

    hib_rst_hold #(.CNT_W(RST_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .active(state_q == ST_RESET_HOLD),
        .limit(rst_val), .done(hold_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:         if (hib_req) state_d = ST_HIBERNATE;
            ST_HIBERNATE:   if (!wake_n) state_d = ST_WAKE_FILTER;
            ST_WAKE_FILTER: begin
                if (qualified)   state_d = ST_RESET_HOLD;
                else if (wake_n) state_d = ST_HIBERNATE;
            end
            ST_RESET_HOLD:  if (hold_done) state_d = ST_RUN;
            default:        state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_en    <= 1'b1;
            sys_rst_n <= 1'b1;
        end else begin
            pwr_en    <= (state_d == ST_RUN) || (state_d == ST_RESET_HOLD);
            sys_rst_n <= (state_d != ST_RESET_HOLD);
        end
    end

    // R5
    off_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> sys_rst_n);
    // R4
    hib_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && hib_req) |=> !pwr_en);
    // R10
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !hib_req) |=> (pwr_en && sys_rst_n));
    // R6
    power_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> !sys_rst_n);
    // R9
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> pwr_en);
endmodule

// File: tb/hib_seq_tb.sv
module hib_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wake_n = 1'b1;
    logic        pwr_en, sys_rst_n;
    int          n_chk = 0;
    int          n_bad = 0;

    localparam logic [7:0] A_HIB = 8'h20, A_FLT = 8'h24, A_RST = 8'h28;

    always #2 clk = ~clk;

    hib_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_n(wake_n),
        .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(pwr_en == 1'b1, "R1 pwr_en", pwr_en, 1);
        check(sys_rst_n == 1'b1, "R1 sys_rst_n", sys_rst_n, 1);
        rd(A_HIB, v); check(v == 0, "R1 hib read", v, 0);
        rd(A_FLT, v); check(v == 0, "R1 flt read", v, 0);
        rd(A_RST, v); check(v == 0, "R1 rst read", v, 0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(A_FLT, 32'hFFFF_FFFF); rd(A_FLT, v); check(v == 32'hFFE0, "R2 all ones", v, 32'hFFE0);
        wr(A_FLT, 32'h1234_0047); rd(A_FLT, v); check(v == 32'h40, "R2 mixed", v, 32'h40);
        wr(A_RST, 32'hFFFF_FFFF); rd(A_RST, v); check(v == 32'hFE0, "R3 all ones", v, 32'hFE0);
        wr(A_RST, 32'h0000_F03F); rd(A_RST, v); check(v == 32'h20, "R3 mixed", v, 32'h20);
    endtask

    task automatic t_run_ignore();
        logic [31:0] v;
        bit ok = 1'b1;
        wake_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!pwr_en || !sys_rst_n) ok = 1'b0;
        end
        wake_n = 1'b1;
        check(ok, "R10 pin ignored in RUN", {pwr_en, sys_rst_n}, 2'b11);
        wr(A_HIB, 32'h0000_0002);
        @(negedge clk);
        rd(A_HIB, v);
        check(pwr_en == 1'b1 && v == 0, "R4 bit0 clear ignored", {pwr_en, v[0]}, 2'b10);
    endtask

    task automatic go_hibernate();
        logic [31:0] v;
        wr(A_HIB, 32'h1);
        rd(A_HIB, v);
        check(pwr_en == 1'b0 && v[0], "R4 hibernate entry", {pwr_en, v[0]}, 2'b01);
        check(sys_rst_n == 1'b1, "R5 reset high while off", sys_rst_n, 1);
        repeat (3) @(negedge clk);
        check(pwr_en == 1'b0 && sys_rst_n, "R5 stays off", {pwr_en, sys_rst_n}, 2'b01);
    endtask

    task automatic measure(input int exp_f, input int exp_h, input string tag);
        int n = 0;
        int m = 1;
        bit early = 1'b0;
        logic [31:0] v;
        wake_n = 1'b0;
        while (n < 70000) begin
            @(negedge clk);
            n++;
            if (!sys_rst_n) break;
            if (pwr_en) early = 1'b1;
        end
        check(!early && n == exp_f + 1, {tag, " wakeup latency"}, n, exp_f + 1);
        check(pwr_en == 1'b1, "R9 power back in hold", pwr_en, 1);
        while (m < 70000) begin
            @(negedge clk);
            if (sys_rst_n) break;
            m++;
        end
        check(m == exp_h, "R9 reset hold length", m, exp_h);
        rd(A_HIB, v);
        check(pwr_en && sys_rst_n && v == 0, "R9 back to RUN", {pwr_en, sys_rst_n, v[0]}, 3'b110);
        wake_n = 1'b1;
    endtask

    task automatic t_filter64();
        wr(A_FLT, 32'h40);
        wr(A_RST, 32'h20);
        go_hibernate();
        measure(64, 32, "R6");
    endtask

    task automatic t_filter0();
        wr(A_FLT, 32'h1F);
        wr(A_RST, 32'hFFFF);
        go_hibernate();
        measure(1, 4064, "R8");
    endtask

    task automatic t_glitch();
        logic [31:0] v;
        wr(A_FLT, 32'h40);
        wr(A_RST, 32'h20);
        go_hibernate();
        wake_n = 1'b0;
        repeat (40) @(negedge clk);
        wake_n = 1'b1;
        repeat (2) @(negedge clk);
        rd(A_HIB, v);
        check(!pwr_en && sys_rst_n && v[0], "R7 short pulse rejected", {pwr_en, sys_rst_n, v[0]}, 3'b011);
        measure(64, 32, "R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_run_ignore();
        t_filter64();
        t_filter0();
        t_glitch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule